// File: doc/BRIEF.md
# Microcoded Datapath Register and Bus Unit

This block holds the 32-bit working registers of a small microcoded stack machine and moves data between them each cycle. One register, picked by a 4-bit source code, is placed on the operand bus that feeds the arithmetic unit. The shifted result comes back on the result bus. A 9-bit write mask then loads that result into any number of registers at the rising clock edge. The arithmetic unit and shifter are outside the block. The result bus is an input and the operand bus is an output. A tenth register, the holding register, is never placed on the operand bus. It goes straight out as the second operand.

Two memory ports sit beside the register set. The data port uses the address register as a word address and the data register as its read and write buffer. The fetch port uses the program counter as a byte address and loads one byte into the fetch register. That byte can be placed on the operand bus sign-extended or zero-extended. Each port turns a one-cycle request strobe into an access in the next cycle. The memory answers combinationally during that access cycle, and the answer is captured at its closing edge.

Top module: `uarch_reg_bus`

## Requirements
- R1: A synchronous active-high reset clears every register to zero, so every source code, the holding-register output and both memory addresses read zero after reset.
- R2: The source code selects the operand bus: 0 data register, 1 program counter, 2 fetch byte sign-extended, 3 fetch byte zero-extended, 4 stack pointer, 5 frame base, 6 constant pool base, 7 top of stack, 8 old-value register; codes 9 to 15 give an all-zero bus.
- R3: The fetch byte is extended to 32 bits by copying its bit 7 upward for code 2, and by filling with zeros for code 3.
- R4: Write mask bits map as bit 0 address, 1 data, 2 program counter, 3 stack pointer, 4 frame base, 5 constant pool base, 6 top of stack, 7 old-value, 8 holding. At the rising edge every register whose bit is set takes the result bus, and every other register keeps its value.
- R5: A register may be on the operand bus and be written in the same cycle: the bus shows the old value in that cycle and the new value afterwards.
- R6: The holding register never reaches the operand bus; its value is always present on the holding-register output.
- R7: A read strobe in cycle k raises the data read enable in cycle k+1, with the data address equal to the address register as loaded at the end of k. The data register holds the returned word at the end of k+1, and it can be read with code 0 in cycle k+2.
- R8: A write strobe in cycle k raises the data write enable in cycle k+1, presenting the address register and the data register as they stand in k+1.
- R9: A fetch strobe in cycle k raises the fetch enable in cycle k+1 with the fetch address equal to the program counter of that cycle. The low byte of the fetched data is held at the end of k+1.
- R10: When returning read data and a mask write to the data register land on the same edge, the read data is stored.
- R11: At most one operand source is enabled in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| b_sel | input | 4 | Operand bus source code |
| c_wr_en | input | 9 | Result bus write mask |
| c_bus | input | 32 | Shifter result |
| mem_read | input | 1 | Data read request |
| mem_write | input | 1 | Data write request |
| mem_fetch | input | 1 | Byte fetch request |
| b_bus | output | 32 | Operand bus |
| h_opnd | output | 32 | Holding register, second operand |
| dmem_addr | output | 32 | Data word address |
| dmem_wdata | output | 32 | Data write word |
| dmem_rd_en | output | 1 | Data read access |
| dmem_wr_en | output | 1 | Data write access |
| dmem_rdata | input | 32 | Data read word |
| imem_addr | output | 32 | Fetch byte address |
| imem_rd_en | output | 1 | Fetch access |
| imem_rdata | input | 8 | Fetched byte |

## Verification
The assertions check four things on every cycle: the decoded operand source stays one-hot or idle, unused codes give a zero bus, each request strobe turns into its access one cycle later, and a completed read or fetch is what the data or fetch code shows next. The bench model follows the register state through long random runs. It is the only way to show that multi-target writes leave unmasked registers alone, that same-cycle read and write of a register shows the old value, and that sign and zero extension hold for bytes on both sides of 0x80. Directed cases cover the collision between read data and a mask write to the data register, and a word written then read back through the data port.

// File: rtl/uarch_bus_pkg.sv
package uarch_bus_pkg;
  // operand bus source codes
  localparam int BS_MDR  = 0;
  localparam int BS_PC   = 1;
  localparam int BS_MBRS = 2;
  localparam int BS_MBRU = 3;
  localparam int BS_SP   = 4;
  localparam int BS_LV   = 5;
  localparam int BS_CPP  = 6;
  localparam int BS_TOS  = 7;
  localparam int BS_OPC  = 8;
  localparam int NUM_BSRC = 9;

  // result bus write mask bit positions
  localparam int CD_MAR = 0;
  localparam int CD_MDR = 1;
  localparam int CD_PC  = 2;
  localparam int CD_SP  = 3;
  localparam int CD_LV  = 4;
  localparam int CD_CPP = 5;
  localparam int CD_TOS = 6;
  localparam int CD_OPC = 7;
  localparam int CD_H   = 8;
  localparam int NUM_CDST = 9;

  typedef struct packed {
    logic rd;
    logic wr;
    logic fetch;
  } memreq_t;
endpackage

// File: rtl/bsrc_decode.sv
module bsrc_decode #(
  parameter int SEL_W = 4,
  parameter int N     = 9
) (
  input  logic [SEL_W-1:0] sel,
  output logic [N-1:0]     en
);
  for (genvar i = 0; i < N; i++) begin : g_dec
    assign en[i] = (sel == SEL_W'(i));
  end
endmodule

// File: rtl/bbus_mux.sv
module bbus_mux #(
  parameter int DW = 32,
  parameter int N  = 9
) (
  input  logic [N*DW-1:0] srcs,
  input  logic [N-1:0]    en,
  output logic [DW-1:0]   y
);
  logic [DW-1:0] acc [N+1];
  assign acc[0] = '0;
  for (genvar i = 0; i < N; i++) begin : g_or
    assign acc[i+1] = acc[i] | (srcs[i*DW +: DW] & {DW{en[i]}});
  end
  assign y = acc[N];
endmodule

// File: rtl/dp_reg.sv
module dp_reg #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] d,
  input  logic          mem_load,
  input  logic [DW-1:0] mem_d,
  output logic [DW-1:0] q
);
  // returning memory data takes priority over a result bus load
  always_ff @(posedge clk) begin
    if (rst)           q <= '0;
    else if (mem_load) q <= mem_d;
    else if (load)     q <= d;
  end
endmodule

// File: rtl/mem_seq.sv
module mem_seq
  import uarch_bus_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  memreq_t req,
  output memreq_t pend
);
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= req;
  end
endmodule

// File: rtl/uarch_reg_bus.sv
module uarch_reg_bus
  import uarch_bus_pkg::*;
#(
  parameter int DW     = 32,
  parameter int SEL_W  = 4,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SEL_W-1:0]    b_sel,
  input  logic [NUM_CDST-1:0] c_wr_en,
  input  logic [DW-1:0]       c_bus,
  input  logic                mem_read,
  input  logic                mem_write,
  input  logic                mem_fetch,
  output logic [DW-1:0]       b_bus,
  output logic [DW-1:0]       h_opnd,
  output logic [DW-1:0]       dmem_addr,
  output logic [DW-1:0]       dmem_wdata,
  output logic                dmem_rd_en,
  output logic                dmem_wr_en,
  input  logic [DW-1:0]       dmem_rdata,
  output logic [DW-1:0]       imem_addr,
  output logic                imem_rd_en,
  input  logic [BYTE_W-1:0]   imem_rdata
);
  localparam int EXT_W = DW - BYTE_W;

  memreq_t req, pend;
  logic [DW-1:0]       regs [NUM_CDST];
  logic [NUM_CDST-1:0] alt_ld;
  logic [BYTE_W-1:0]   mbr_q;
  logic [NUM_BSRC-1:0] src_en;
  logic [NUM_BSRC*DW-1:0] srcs;

  assign req.rd    = mem_read;
  assign req.wr    = mem_write;
  assign req.fetch = mem_fetch;

  mem_seq u_seq (
    .clk  (clk),
    .rst  (rst),
    .req  (req),
    .pend (pend)
  );

  assign alt_ld = NUM_CDST'(pend.rd) << CD_MDR;

  for (genvar i = 0; i < NUM_CDST; i++) begin : g_reg
    dp_reg #(.DW(DW)) u_reg (
      .clk      (clk),
      .rst      (rst),
      .load     (c_wr_en[i]),
      .d        (c_bus),
      .mem_load (alt_ld[i]),
      .mem_d    (dmem_rdata),
      .q        (regs[i])
    );
  end

  dp_reg #(.DW(BYTE_W)) u_mbr (
    .clk      (clk),
    .rst      (rst),
    .load     (1'b0),
    .d        ({BYTE_W{1'b0}}),
    .mem_load (pend.fetch),
    .mem_d    (imem_rdata),
    .q        (mbr_q)
  );

  bsrc_decode #(.SEL_W(SEL_W), .N(NUM_BSRC)) u_dec (
    .sel (b_sel),
    .en  (src_en)
  );

  assign srcs[BS_MDR*DW  +: DW] = regs[CD_MDR];
  assign srcs[BS_PC*DW   +: DW] = regs[CD_PC];
  assign srcs[BS_MBRS*DW +: DW] = {{EXT_W{mbr_q[BYTE_W-1]}}, mbr_q};
  assign srcs[BS_MBRU*DW +: DW] = {{EXT_W{1'b0}}, mbr_q};
  assign srcs[BS_SP*DW   +: DW] = regs[CD_SP];
  assign srcs[BS_LV*DW   +: DW] = regs[CD_LV];
  assign srcs[BS_CPP*DW  +: DW] = regs[CD_CPP];
  assign srcs[BS_TOS*DW  +: DW] = regs[CD_TOS];
  assign srcs[BS_OPC*DW  +: DW] = regs[CD_OPC];

  bbus_mux #(.DW(DW), .N(NUM_BSRC)) u_mux (
    .srcs (srcs),
    .en   (src_en),
    .y    (b_bus)
  );

  assign h_opnd     = regs[CD_H];
  assign dmem_addr  = regs[CD_MAR];
  assign dmem_wdata = regs[CD_MDR];
  assign dmem_rd_en = pend.rd;
  assign dmem_wr_en = pend.wr;
  assign imem_addr  = regs[CD_PC];
  assign imem_rd_en = pend.fetch;
endmodule

// File: rtl/uarch_reg_bus_chk.sv
module uarch_reg_bus_chk #(
  parameter int DW     = 32,
  parameter int SEL_W  = 4,
  parameter int BYTE_W = 8,
  parameter int NSRC   = 9,
  parameter int NDST   = 9
) (
  input logic              clk,
  input logic              rst,
  input logic [SEL_W-1:0]  b_sel,
  input logic [NDST-1:0]   c_wr_en,
  input logic [DW-1:0]     c_bus,
  input logic              mem_read,
  input logic              mem_write,
  input logic              mem_fetch,
  input logic [DW-1:0]     b_bus,
  input logic [DW-1:0]     h_opnd,
  input logic [DW-1:0]     dmem_addr,
  input logic              dmem_rd_en,
  input logic              dmem_wr_en,
  input logic [DW-1:0]     dmem_rdata,
  input logic              imem_rd_en,
  input logic [BYTE_W-1:0] imem_rdata,
  input logic [NSRC-1:0]   src_en
);
  assert_src_onehot_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(src_en));

  assert_idle_code_R2: assert property (@(posedge clk) disable iff (rst)
    (b_sel >= SEL_W'(NSRC)) |-> (b_bus == '0));

  assert_read_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    mem_read |=> dmem_rd_en);

  assert_read_addr_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_read && c_wr_en[0]) |=> (dmem_addr == $past(c_bus)));

  assert_write_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    mem_write |=> dmem_wr_en);

  assert_fetch_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    mem_fetch |=> imem_rd_en);

  assert_read_wins_R10: assert property (@(posedge clk) disable iff (rst)
    dmem_rd_en |=> ((b_sel != SEL_W'(0)) || (b_bus == $past(dmem_rdata))));

  assert_fetch_zext_R3: assert property (@(posedge clk) disable iff (rst)
    imem_rd_en |=> ((b_sel != SEL_W'(3)) ||
                    (b_bus == {{(DW-BYTE_W){1'b0}}, $past(imem_rdata)})));

  assert_hold_load_R6: assert property (@(posedge clk) disable iff (rst)
    c_wr_en[NDST-1] |=> (h_opnd == $past(c_bus)));
endmodule

bind uarch_reg_bus uarch_reg_bus_chk #(
  .DW(DW), .SEL_W(SEL_W), .BYTE_W(BYTE_W),
  .NSRC(uarch_bus_pkg::NUM_BSRC), .NDST(uarch_bus_pkg::NUM_CDST)
) u_chk (
  .clk(clk), .rst(rst), .b_sel(b_sel), .c_wr_en(c_wr_en), .c_bus(c_bus),
  .mem_read(mem_read), .mem_write(mem_write), .mem_fetch(mem_fetch),
  .b_bus(b_bus), .h_opnd(h_opnd), .dmem_addr(dmem_addr),
  .dmem_rd_en(dmem_rd_en), .dmem_wr_en(dmem_wr_en), .dmem_rdata(dmem_rdata),
  .imem_rd_en(imem_rd_en), .imem_rdata(imem_rdata), .src_en(src_en)
);

// File: tb/uarch_reg_bus_tb_top.sv
module uarch_reg_bus_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  b_sel = '0;
  logic [8:0]  c_wr_en = '0;
  logic [31:0] c_bus = '0;
  logic        mem_read = 1'b0, mem_write = 1'b0, mem_fetch = 1'b0;
  logic [31:0] b_bus, h_opnd, dmem_addr, dmem_wdata, dmem_rdata, imem_addr;
  logic        dmem_rd_en, dmem_wr_en, imem_rd_en;
  logic [7:0]  imem_rdata;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  uarch_reg_bus dut_i (
    .clk(clk), .rst(rst), .b_sel(b_sel), .c_wr_en(c_wr_en), .c_bus(c_bus),
    .mem_read(mem_read), .mem_write(mem_write), .mem_fetch(mem_fetch),
    .b_bus(b_bus), .h_opnd(h_opnd), .dmem_addr(dmem_addr),
    .dmem_wdata(dmem_wdata), .dmem_rd_en(dmem_rd_en), .dmem_wr_en(dmem_wr_en),
    .dmem_rdata(dmem_rdata), .imem_addr(imem_addr), .imem_rd_en(imem_rd_en),
    .imem_rdata(imem_rdata)
  );

  // memory models
  logic [31:0] dmem [256];
  function automatic logic [7:0] ibyte(input logic [31:0] a);
    return a[7:0] ^ 8'hA5;
  endfunction
  assign dmem_rdata = dmem[dmem_addr[7:0]];
  assign imem_rdata = ibyte(imem_addr);
  always @(posedge clk) if (dmem_wr_en) dmem[dmem_addr[7:0]] <= dmem_wdata;

  // reference state (mask bit order: MAR MDR PC SP LV CPP TOS OPC H)
  logic [31:0] m [9];
  logic [7:0]  mb;
  logic        pr, pw, pf;

  function automatic logic [31:0] exp_b(input logic [3:0] s);
    case (s)
      4'd0: return m[1];
      4'd1: return m[2];
      4'd2: return {{24{mb[7]}}, mb};
      4'd3: return {24'h0, mb};
      4'd4: return m[3];
      4'd5: return m[4];
      4'd6: return m[5];
      4'd7: return m[6];
      4'd8: return m[7];
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic [3:0] s, input logic [8:0] msk,
                      input logic [31:0] cv, input logic rd, input logic wr, input logic ft);
    logic [31:0] nm [9];
    @(negedge clk);
    b_sel = s; c_wr_en = msk; c_bus = cv;
    mem_read = rd; mem_write = wr; mem_fetch = ft;
    #2;
    chk({tag, " b_bus"}, b_bus, exp_b(s));
    chk("R6 h_opnd", h_opnd, m[8]);
    chk("R7 dmem_rd_en", {31'h0, dmem_rd_en}, {31'h0, pr});
    chk("R8 dmem_wr_en", {31'h0, dmem_wr_en}, {31'h0, pw});
    chk("R9 imem_rd_en", {31'h0, imem_rd_en}, {31'h0, pf});
    if (pr || pw) chk("R7 dmem_addr", dmem_addr, m[0]);
    if (pw) chk("R8 dmem_wdata", dmem_wdata, m[1]);
    if (pf) chk("R9 imem_addr", imem_addr, m[2]);
    for (int i = 0; i < 9; i++) nm[i] = msk[i] ? cv : m[i];
    if (pr) nm[1] = dmem[m[0][7:0]];  // R10: read data wins
    if (pf) mb = ibyte(m[2]);
    for (int i = 0; i < 9; i++) m[i] = nm[i];
    pr = rd; pw = wr; pf = ft;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) dmem[i] = (32'(i) * 32'h01010101) ^ 32'hC3A50000;
  end

  initial begin : wdog
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 9; i++) m[i] = 32'hFFFF_FFFF;
    mb = 8'hFF; pr = 0; pw = 0; pf = 0;
    repeat (3) @(posedge clk);
    // registers hold garbage-free zero after reset
    for (int i = 0; i < 9; i++) m[i] = '0;
    mb = '0;
    @(negedge clk); rst = 1'b0;
    // R1: every source code reads zero after reset
    for (int s = 0; s < 16; s++) step("R1", 4'(s), 9'h0, 32'h0, 0, 0, 0);
    chk("R1 dmem_addr", dmem_addr, 32'h0);
    chk("R1 imem_addr", imem_addr, 32'h0);

    // R4: write all targets at once, then read every source
    step("R4", 4'd0, 9'h1FF, 32'h1234_5678, 0, 0, 0);
    for (int s = 0; s < 16; s++) step("R4/R2", 4'(s), 9'h0, 32'h0, 0, 0, 0);
    // R4: partial mask leaves others unchanged
    step("R4", 4'd4, 9'b0_0010_1000, 32'hCAFE_0001, 0, 0, 0);
    for (int s = 0; s < 9; s++) step("R4", 4'(s), 9'h0, 32'h0, 0, 0, 0);

    // R5: read and write top of stack in one cycle
    step("R5 old", 4'd7, 9'b0_0100_0000, 32'hAAAA_5555, 0, 0, 0);
    step("R5 new", 4'd7, 9'h0, 32'h0, 0, 0, 0);

    // R3/R9: PC=0x5A fetches 0xFF (negative), PC=0xA0 fetches 0x05
    step("R9", 4'd1, 9'b0_0000_0100, 32'h0000_005A, 0, 0, 1);
    step("R9", 4'd1, 9'h0, 32'h0, 0, 0, 0);
    step("R3 sext neg", 4'd2, 9'h0, 32'h0, 0, 0, 0);
    chk("R3 sext value", b_bus, 32'hFFFF_FFFF);
    step("R3 zext neg", 4'd3, 9'h0, 32'h0, 0, 0, 0);
    chk("R3 zext value", b_bus, 32'h0000_00FF);
    step("R9", 4'd1, 9'b0_0000_0100, 32'h0000_00A0, 0, 0, 1);
    step("R9", 4'd1, 9'h0, 32'h0, 0, 0, 0);
    step("R3 sext pos", 4'd2, 9'h0, 32'h0, 0, 0, 0);
    chk("R3 sext pos value", b_bus, 32'h0000_0005);

    // R7: read word 5, visible two cycles later
    step("R7", 4'd0, 9'b0_0000_0001, 32'h5, 1, 0, 0);
    step("R7", 4'd0, 9'h0, 32'h0, 0, 0, 0);
    step("R7 data", 4'd0, 9'h0, 32'h0, 0, 0, 0);
    chk("R7 data value", b_bus, dmem[5]);

    // R10: mask write to data register collides with read data
    step("R10", 4'd0, 9'b0_0000_0001, 32'h9, 1, 0, 0);
    step("R10", 4'd0, 9'b0_0000_0010, 32'hDEAD_BEEF, 0, 0, 0);
    step("R10 data", 4'd0, 9'h0, 32'h0, 0, 0, 0);
    chk("R10 value", b_bus, dmem[9]);

    // R8: write word 7 then read it back
    step("R8", 4'd0, 9'b0_0000_0010, 32'h0BAD_F00D, 0, 0, 0);
    step("R8", 4'd0, 9'b0_0000_0001, 32'h7, 0, 1, 0);
    step("R8", 4'd0, 9'h0, 32'h0, 0, 0, 0);
    step("R8", 4'd0, 9'b0_0000_0010, 32'h0, 1, 0, 0);
    step("R8", 4'd0, 9'h0, 32'h0, 0, 0, 0);
    step("R8 readback", 4'd0, 9'h0, 32'h0, 0, 0, 0);
    chk("R8 readback value", b_bus, 32'h0BAD_F00D);

    // random traffic; R11 is shown by a single clean source per code
    for (int n = 0; n < 4000; n++) begin
      logic [3:0] s; logic [8:0] k; logic [31:0] v; logic rd, wr;
      s = 4'($urandom);
      k = 9'($urandom) & 9'($urandom);
      v = (($urandom % 4) == 0) ? {24'h0, 8'($urandom)} : $urandom;
      rd = (($urandom % 4) == 0);
      wr = !rd && (($urandom % 5) == 0);
      step("R2/R4/R11", s, k, v, rd, wr, (($urandom % 3) == 0));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule